// File: doc/BRIEF.md
# Programmable Tick Timer

A 32-bit tick counter with a companion control word that holds an operating mode, an interrupt enable, a pending flag and a 28-bit match value. Software reaches both words through a single write strobe, a one-bit register select, a write data bus and a read data bus. While the timer runs, the counter advances by one every clock. When its low 28 bits equal the match value, the pending flag is raised and the selected mode decides what the counter does next.

Starting and stopping are tied to changes of the mode field. A control write that changes the mode to "off" halts the counter. A write that changes it to any other mode starts the counter. A write that repeats the current mode leaves the run state as it is, so a one-shot timer that has fired stays stopped when its control word is rewritten unchanged. Software can only clear the pending flag. Writing the pending bit as 1 leaves the flag as it was, and writing it as 0 clears it.

Top module: `tick_timer`

## Requirements
- R1: After reset, both the control word and the counter read 0, `irq` is 0 and the counter does not advance.
- R2: Control word layout: bits 31:30 hold the mode (00 off, 01 restart-on-match, 10 one-shot, 11 free-run), bit 29 the interrupt enable, bit 28 the pending flag and bits 27:0 the match value. A write that changes the mode to 00 stops counting, and a write that changes it to any non-zero mode starts counting.
- R3: A control write whose mode field equals the current mode neither starts nor stops the counter.
- R4: A control write with bit 28 set leaves the pending flag unchanged and never sets it. A control write with bit 28 clear clears the flag, and `irq` is low from the next cycle on.
- R5: A count write (`reg_sel`=1) loads the counter with `wr_data` on that edge, with priority over counting.
- R6: `rd_data` shows the control word when `reg_sel`=0 and the live counter value when `reg_sel`=1, with no added latency.
- R7: A match is a running counter whose bits 27:0 equal the match value. A match sets the pending flag on that edge, and `irq` equals the pending flag AND the interrupt enable.
- R8: In restart mode a match returns the counter to 0.
- R9: In one-shot mode a match stops the counter, which holds the match value.
- R10: In free-run mode a match does not disturb counting, and the counter wraps from all ones to 0.
- R11: While running, the counter advances by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | 0 selects the control word, 1 the counter |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Interrupt: pending AND enable |

## Verification
A write takes effect on the clock edge at which the strobe is sampled. The bench holds the strobe for one full cycle from a falling edge and reads the result at the next falling edge, one register stage later. Reads are combinational, so both words are sampled a fraction of a nanosecond after `reg_sel` changes, inside the low half of the clock. A match seen on edge N shows in the pending flag, in `irq` and in the counter's restart, hold or increment at edge N+1. In restart mode with match value M, starting from 0, this puts the pending flag M+1 edges after the starting write, and the directed checks use those hand-derived cycle counts.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_FREE    = 2'b11
  } tt_mode_e;

  typedef enum logic {
    TT_SEL_CTRL  = 1'b0,
    TT_SEL_COUNT = 1'b1
  } tt_sel_e;
endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              match_evt,
  output tt_mode_e          mode_o,
  output logic              ie_o,
  output logic              pend_o,
  output logic [DATA_W-5:0] match_o,
  output logic              run_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int MODE_HI  = DATA_W - 1;
  localparam int IE_BIT   = DATA_W - 3;
  localparam int PEND_BIT = DATA_W - 4;
  localparam int MATCH_W  = DATA_W - 4;

  tt_mode_e          mode_q;
  logic              ie_q, pend_q, run_q;
  logic [MATCH_W-1:0] match_q;
  tt_mode_e          wr_mode;

  assign wr_mode = tt_mode_e'(wr_data[MODE_HI -: 2]);

  // run state: only a change of mode field starts or stops; one-shot match stops
  function automatic logic f_next_run(input logic wr, input tt_mode_e cur,
                                      input tt_mode_e nxt, input logic run,
                                      input logic hit);
    if (wr && (nxt != cur)) return (nxt != TT_OFF);
    if (hit && (cur == TT_ONESHOT)) return 1'b0;
    return run;
  endfunction

  // pending: software may keep (1) or clear (0), never set; match sets
  function automatic logic f_next_pend(input logic wr, input logic keep,
                                       input logic pend, input logic hit);
    logic p;
    p = wr ? (keep & pend) : pend;
    return p | hit;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TT_OFF;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      match_q <= '0;
    end else begin
      run_q  <= f_next_run(wr_ctrl, mode_q, wr_mode, run_q, match_evt);
      pend_q <= f_next_pend(wr_ctrl, wr_data[PEND_BIT], pend_q, match_evt);
      if (wr_ctrl) begin
        mode_q  <= wr_mode;
        ie_q    <= wr_data[IE_BIT];
        match_q <= wr_data[MATCH_W-1:0];
      end
    end
  end

  assign mode_o  = mode_q;
  assign ie_o    = ie_q;
  assign pend_o  = pend_q;
  assign match_o = match_q;
  assign run_o   = run_q;
  assign word_o  = {mode_q, ie_q, pend_q, match_q};
endmodule

// File: rtl/tt_match.sv
module tt_match #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-5:0] count_lo,
  input  logic [DATA_W-5:0] match_val,
  input  logic              run,
  output logic              hit
);
  function automatic logic f_hit(input logic [DATA_W-5:0] c,
                                 input logic [DATA_W-5:0] m,
                                 input logic r);
    return r && (c == m);
  endfunction

  assign hit = f_hit(count_lo, match_val, run);
endmodule

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  input  logic              match_evt,
  input  tt_mode_e          mode,
  output logic [DATA_W-1:0] count_o
);
  logic [DATA_W-1:0] count_q;

  function automatic logic [DATA_W-1:0] f_advance(input logic [DATA_W-1:0] c,
                                                  input tt_mode_e m,
                                                  input logic hit);
    if (hit && (m == TT_RESTART)) return '0;
    if (hit && (m == TT_ONESHOT)) return c;
    return c + DATA_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (load)   count_q <= load_val;
    else if (run)    count_q <= f_advance(count_q, mode, match_evt);
  end

  assign count_o = count_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int MATCH_W = DATA_W - 4;

  tt_sel_e            sel;
  logic               wr_ctrl, wr_cnt;
  tt_mode_e           mode_q;
  logic               ie_q, pend_q, run_q, match_evt;
  logic [MATCH_W-1:0] match_q;
  logic [DATA_W-1:0]  ctrl_word, count_q;

  assign sel     = tt_sel_e'(reg_sel);
  assign wr_ctrl = wr_en && (sel == TT_SEL_CTRL);
  assign wr_cnt  = wr_en && (sel == TT_SEL_COUNT);

  tt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .match_evt(match_evt), .mode_o(mode_q), .ie_o(ie_q), .pend_o(pend_q),
    .match_o(match_q), .run_o(run_q), .word_o(ctrl_word)
  );

  tt_match #(.DATA_W(DATA_W)) u_match (
    .count_lo(count_q[MATCH_W-1:0]), .match_val(match_q), .run(run_q),
    .hit(match_evt)
  );

  tt_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(wr_data),
    .run(run_q), .match_evt(match_evt), .mode(mode_q), .count_o(count_q)
  );

  assign rd_data = (sel == TT_SEL_COUNT) ? count_q : ctrl_word;
  assign irq     = pend_q & ie_q;
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic              run,
  input logic              pend,
  input tt_mode_e          mode,
  input logic              match_evt
);
  logic     wr_ctrl, wr_cnt;
  tt_mode_e wmode;
  assign wr_ctrl = wr_en && !reg_sel;
  assign wr_cnt  = wr_en && reg_sel;
  assign wmode   = tt_mode_e'(wr_data[DATA_W-1 -: 2]);

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wmode == TT_OFF && mode != TT_OFF |=> !run);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wmode != TT_OFF && wmode != mode |=> run);
  p_same_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wmode == mode && !match_evt |=> run == $past(run));
  p_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !pend && !match_evt |=> !pend);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !wr_data[DATA_W-4] && !match_evt |=> !irq);
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(wr_data));
  p_match_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> pend);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && mode == TT_RESTART && !wr_cnt |=> count == '0);
  p_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && mode == TT_ONESHOT && !wr_en |=> !run && $stable(count));
  p_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt && mode == TT_FREE && !wr_cnt |=> count == $past(count) + DATA_W'(1));
  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wr_cnt && !match_evt |=> count == $past(count) + DATA_W'(1));
endmodule

bind tick_timer tt_checker #(.DATA_W(DATA_W)) u_tt_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .irq(irq), .count(count_q), .run(run_q),
  .pend(pend_q), .mode(mode_q), .match_evt(match_evt)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/100ps
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;   // 250 MHz

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // reference model written from the requirements
  logic [1:0]  m_mode;
  logic        m_ie, m_pend, m_run;
  logic [27:0] m_mv;
  logic [31:0] m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'd0; m_ie = 1'b0; m_pend = 1'b0; m_run = 1'b0;
      m_mv = '0; m_cnt = '0;
    end else begin
      logic hit, n_run, n_pend;
      logic [31:0] n_cnt;
      hit = m_run && (m_cnt[27:0] == m_mv);
      n_run = m_run;
      if (wr_en && !reg_sel && wr_data[31:30] != m_mode) n_run = (wr_data[31:30] != 2'd0);
      else if (hit && m_mode == 2'd2) n_run = 1'b0;
      n_pend = (wr_en && !reg_sel) ? (wr_data[28] & m_pend) : m_pend;
      if (hit) n_pend = 1'b1;
      n_cnt = m_cnt;
      if (wr_en && reg_sel) n_cnt = wr_data;
      else if (m_run) begin
        if (hit && m_mode == 2'd1) n_cnt = '0;
        else if (!(hit && m_mode == 2'd2)) n_cnt = m_cnt + 32'd1;
      end
      if (wr_en && !reg_sel) begin
        m_mode = wr_data[31:30]; m_ie = wr_data[29]; m_mv = wr_data[27:0];
      end
      m_run = n_run; m_pend = n_pend; m_cnt = n_cnt;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // read both words and irq within the low clock phase
  task automatic read_pair(output logic [31:0] c_word, output logic [31:0] c_cnt);
    reg_sel = 1'b0; #0.5; c_word = rd_data;
    reg_sel = 1'b1; #0.5; c_cnt = rd_data;
    reg_sel = 1'b0;
  endtask

  task automatic check_model(input string req);
    logic [31:0] w, c;
    read_pair(w, c);
    chk({req, " ctrl word (R6)"}, w, {m_mode, m_ie, m_pend, m_mv});
    chk({req, " count (R6)"}, c, m_cnt);
    chk({req, " irq (R7)"}, {31'd0, irq}, {31'd0, m_pend & m_ie});
  endtask

  task automatic do_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // {op[1:0], data[31:0], gap[7:0]}; op 0 idle, 1 control write, 2 count write
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {2'd1, 32'h6000_0005, 8'd3},   // R2 start restart, match 5
    {2'd0, 32'h0000_0000, 8'd4},   // R7 R8 pass through match
    {2'd1, 32'h7000_0005, 8'd0},   // R3 R4 same mode, keep pending
    {2'd1, 32'h6000_0005, 8'd0},   // R4 clear pending
    {2'd2, 32'h0000_0064, 8'd2},   // R5 load 100
    {2'd1, 32'hA000_0070, 8'd15},  // R9 one-shot at 112
    {2'd1, 32'hB000_0070, 8'd3},   // R3 stays stopped
    {2'd1, 32'h0000_0000, 8'd2},   // R2 stop
    {2'd2, 32'hFFFF_FFFD, 8'd2},   // R5 load while stopped
    {2'd1, 32'hC000_0001, 8'd6},   // R10 free-run wrap and match
    {2'd1, 32'hF000_0001, 8'd1},   // R4 keep
    {2'd1, 32'h4000_0003, 8'd5}    // R7 enable off masks irq
  };

  initial begin
    logic [31:0] w, c;
    // R1 reset state
    do_reset();
    read_pair(w, c);
    chk("R1 ctrl after reset", w, 32'h0);
    chk("R1 count after reset", c, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    repeat (3) @(negedge clk);
    read_pair(w, c);
    chk("R1 idle count stays 0", c, 32'h0);

    // R4: writing pending as 1 never sets it
    do_wr(1'b0, 32'h3000_0000);
    read_pair(w, c);
    chk("R4 pending not set by write", w, 32'h2000_0000);
    chk("R4 irq not set by write", {31'd0, irq}, 32'd0);

    // table-driven sequence
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] d;
      logic [7:0]  g;
      {op, d, g} = VEC[i];
      if (op == 2'd1) do_wr(1'b0, d);
      else if (op == 2'd2) do_wr(1'b1, d);
      repeat (int'(g)) @(negedge clk);
      check_model($sformatf("vec%0d", i));
    end

    // R8 R11 restart with match 2: count 2 after two edges, then 0 with pending
    do_reset();
    do_wr(1'b0, 32'h6000_0002);
    @(negedge clk); @(negedge clk);
    read_pair(w, c);
    chk("R11 count two after two edges", c, 32'd2);
    chk("R7 no irq before match", {31'd0, irq}, 32'd0);
    @(negedge clk);
    read_pair(w, c);
    chk("R8 restart to zero", c, 32'd0);
    chk("R7 irq after match", {31'd0, irq}, 32'd1);

    // R9 one-shot: load 10, match 12, holds at 12
    do_reset();
    do_wr(1'b1, 32'd10);
    do_wr(1'b0, 32'hA000_000C);
    repeat (5) @(negedge clk);
    read_pair(w, c);
    chk("R9 one-shot holds match value", c, 32'd12);
    chk("R9 irq after one-shot", {31'd0, irq}, 32'd1);
    do_wr(1'b0, 32'hB000_000C);
    repeat (3) @(negedge clk);
    read_pair(w, c);
    chk("R3 same mode does not restart", c, 32'd12);
    chk("R4 pending kept", w, 32'hB000_000C);
    do_wr(1'b0, 32'hA000_000C);
    read_pair(w, c);
    chk("R4 cleared irq", {31'd0, irq}, 32'd0);

    // R10 wrap at 32 bits
    do_reset();
    do_wr(1'b1, 32'hFFFF_FFFF);
    do_wr(1'b0, 32'hCFFF_FFF0);
    @(negedge clk);
    read_pair(w, c);
    chk("R10 wrap to zero", c, 32'd0);

    // R2 stop holds count
    do_wr(1'b0, 32'h0FFF_FFF0);
    read_pair(w, c);
    repeat (3) @(negedge clk);
    begin
      logic [31:0] w2, c2;
      read_pair(w2, c2);
      chk("R2 stopped counter holds", c2, c);
    end

    finish_run();
  end
endmodule